// File: doc/BRIEF.md
# PLL Counter Parameter Calculator

This block turns a requested output frequency, the system clock frequency and a pixel count into three ready-to-use words: a fractional frequency word for a phase accumulator, a control word carrying the PLL divider select, and a video scale word holding a rounded pixel-clock divisor. It works in phases:
- It shifts the request into the accumulator's legal reference band.
- It forms the 32-bit binary fraction reference/system-clock one bit per cycle.
- It searches for the divider select.
- It performs a rounded integer division for the pixel divisor.

Software or a sequencer drives the operands, pulses `start`, and collects the results when `done` pulses. One restoring divide step serves both the fraction and the integer division, so the block holds a single subtractor. The request must exceed 2 kHz and the system clock should be above 8 MHz. The reference after normalisation must be below the system clock.

Top module: `pll_calc`

## Requirements
- R1: After reset `busy` and `done` are 0 and `frqWord`, `ctrlWord` and `scaleWord` are 0.
- R2: The reference value starts at `reqFreq`. While it exceeds 8,000,000 it is halved by a right shift. Then, while it is below 4,000,000, it is doubled by a left shift. This leaves it in the range 4,000,000 to 8,000,000.
- R3: `frqWord` equals floor(reference × 2^32 / `sysFreq`), formed over exactly 32 divide steps.
- R4: The select starts at 7 with the reference multiplied by 16. While the select is nonzero and the value exceeds `reqFreq` + floor(`reqFreq`/2), the select is decremented and the value halved. `ctrlWord` is `ctrlBase` ORed with the select placed in bits 25:23.
- R5: The pixel divisor is floor((value + floor(`reqFreq`/2)) / `reqFreq`), clamped to the range 1..255. `scaleWord` = (divisor << 12) + divisor × `pixels`, modulo 2^32.
- R6: `done` is high for exactly one cycle per accepted start, and `busy` is high from the cycle after the accepted start through the `done` cycle.
- R7: A `start` while `busy` is high is ignored: operands presented with it do not affect the results of the running job.
- R8: `done` is high in the cycle that follows rising edge number 67+H+S, counting the edge that sampled `start` as edge 1. H is the number of normalising shifts and S the number of select decrements.
- R9: The result outputs change only on the edge that raises `done` and hold their values until the next job completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted when not busy) |
| reqFreq | input | 32 | Requested output frequency in Hz |
| sysFreq | input | 32 | System clock frequency in Hz |
| pixels | input | 32 | Pixel count per scale frame |
| ctrlBase | input | 32 | Control word to merge the select into |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| frqWord | output | 32 | Fractional frequency word |
| ctrlWord | output | 32 | Control word with divider select |
| scaleWord | output | 32 | Video scale word |

## Verification
The latency is not fixed: it depends on how many normalising shifts and select decrements the operands cause. The bench model therefore derives H and S for each vector and expects `done` exactly 67+H+S rising edges after `start` is sampled. It counts edges from the start edge, samples on falling edges, and reads the three result words in the `done` cycle. It checks that `done` is low one cycle later and that the words are unchanged twenty idle cycles after that.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_RATIO,
    ST_SEARCH,
    ST_PIXDIV,
    ST_FINISH
  } calcState_t;

  typedef struct packed {
    logic loadOps;
    logic shiftDown;
    logic shiftUp;
    logic ratioInit;
    logic divStep;
    logic useSys;
    logic searchInit;
    logic searchStep;
    logic pixInit;
    logic frqCapture;
    logic resultCapture;
  } calcStrobes_t;

  typedef struct packed {
    logic driveHigh;
    logic driveLow;
    logic searchGo;
  } calcStatus_t;

endpackage

// File: rtl/pll_calc_divstep.sv
module pll_calc_divstep #(
  parameter int W = 32
) (
  input  logic [W-1:0] remIn,
  input  logic [W-1:0] quoIn,
  input  logic [W-1:0] den,
  output logic [W-1:0] remOut,
  output logic [W-1:0] quoOut
);

  logic [W:0] trial;
  logic [W:0] diff;
  logic       ge;

  always_comb begin
    trial  = {remIn, quoIn[W-1]};
    diff   = trial - {1'b0, den};
    ge     = trial >= {1'b0, den};
    remOut = ge ? diff[W-1:0] : trial[W-1:0];
    quoOut = {quoIn[W-2:0], ge};
  end

endmodule

// File: rtl/pll_calc_ctrl.sv
module pll_calc_ctrl
  import pll_calc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  calcStatus_t  status,
  output calcStrobes_t strobes,
  output logic         busy,
  output logic         done
);

  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

  calcState_t state, stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.loadOps = 1'b1;
          stateNext       = ST_NORM;
        end
      end
      ST_NORM: begin
        if (status.driveHigh) begin
          strobes.shiftDown = 1'b1;
        end else if (status.driveLow) begin
          strobes.shiftUp = 1'b1;
        end else begin
          strobes.ratioInit = 1'b1;
          stateNext         = ST_RATIO;
        end
      end
      ST_RATIO: begin
        strobes.divStep = 1'b1;
        strobes.useSys  = 1'b1;
        if (stepCnt == LAST_STEP) begin
          strobes.frqCapture = 1'b1;
          strobes.searchInit = 1'b1;
          stateNext          = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        if (status.searchGo) begin
          strobes.searchStep = 1'b1;
        end else begin
          strobes.pixInit = 1'b1;
          stateNext       = ST_PIXDIV;
        end
      end
      ST_PIXDIV: begin
        strobes.divStep = 1'b1;
        if (stepCnt == LAST_STEP) begin
          strobes.resultCapture = 1'b1;
          stateNext             = ST_FINISH;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobes.ratioInit || strobes.pixInit) stepCnt <= '0;
      else if (strobes.divStep)                 stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  ratio_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RATIO && stepCnt == LAST_STEP) |=> (state == ST_SEARCH));

endmodule

// File: rtl/pll_calc_dp.sv
module pll_calc_dp
  import pll_calc_pkg::*;
#(
  parameter int          W           = 32,
  parameter logic [31:0] LO_REF      = 32'd4_000_000,
  parameter logic [31:0] HI_REF      = 32'd8_000_000,
  parameter int          SEL_BITS    = 3,
  parameter int          SEL_POS     = 23,
  parameter int          VCO_SHIFT   = 4,
  parameter int          SCALE_SHIFT = 12,
  parameter int          DIV_MAX     = 255
) (
  input  logic         clk,
  input  logic         rstN,
  input  calcStrobes_t strobes,
  input  logic [W-1:0] reqFreq,
  input  logic [W-1:0] sysFreq,
  input  logic [W-1:0] pixels,
  input  logic [W-1:0] ctrlBase,
  output calcStatus_t  status,
  output logic [W-1:0] frqWord,
  output logic [W-1:0] ctrlWord,
  output logic [W-1:0] scaleWord
);

  localparam int DIV_W = $clog2(DIV_MAX + 1);
  localparam logic [SEL_BITS-1:0] SEL_START = '1;
  localparam logic [W-1:0] LO_W = W'(LO_REF);
  localparam logic [W-1:0] HI_W = W'(HI_REF);

  logic [W-1:0] freqReg, sysReg, pixReg, baseReg;
  logic [W-1:0] drive, remReg, quoReg, frqHold;
  logic [SEL_BITS-1:0] selReg;
  logic [DIV_W-1:0] pixDiv;

  logic [W-1:0] den, remNext, quoNext;
  logic [W:0]   thresh;
  logic [DIV_W-1:0] divClamp;
  logic [W-1:0] divWide;

  assign den    = strobes.useSys ? sysReg : freqReg;
  assign thresh = {1'b0, freqReg} + {2'b0, freqReg[W-1:1]};

  always_comb begin
    status.driveHigh = drive > HI_W;
    status.driveLow  = (drive < LO_W) && (drive != '0);
    status.searchGo  = (selReg != '0) && ({1'b0, drive} > thresh);
  end

  pll_calc_divstep #(.W(W)) u_divstep (
    .remIn (remReg),
    .quoIn (quoReg),
    .den   (den),
    .remOut(remNext),
    .quoOut(quoNext)
  );

  always_comb begin
    if (quoNext == '0)                divClamp = DIV_W'(1);
    else if (quoNext > W'(DIV_MAX))   divClamp = DIV_W'(DIV_MAX);
    else                              divClamp = quoNext[DIV_W-1:0];
    divWide = W'(divClamp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqReg   <= '0;
      sysReg    <= '0;
      pixReg    <= '0;
      baseReg   <= '0;
      drive     <= '0;
      remReg    <= '0;
      quoReg    <= '0;
      frqHold   <= '0;
      selReg    <= '0;
      pixDiv    <= '0;
      frqWord   <= '0;
      ctrlWord  <= '0;
      scaleWord <= '0;
    end else begin
      if (strobes.loadOps) begin
        freqReg <= reqFreq;
        sysReg  <= sysFreq;
        pixReg  <= pixels;
        baseReg <= ctrlBase;
        drive   <= reqFreq;
      end
      if (strobes.shiftDown) drive <= drive >> 1;
      if (strobes.shiftUp)   drive <= drive << 1;
      if (strobes.ratioInit) begin
        remReg <= drive;
        quoReg <= '0;
      end
      if (strobes.pixInit) begin
        remReg <= '0;
        quoReg <= drive + (freqReg >> 1);
      end
      if (strobes.divStep) begin
        remReg <= remNext;
        quoReg <= quoNext;
      end
      if (strobes.frqCapture) frqHold <= quoNext;
      if (strobes.searchInit) begin
        selReg <= SEL_START;
        drive  <= drive << VCO_SHIFT;
      end
      if (strobes.searchStep) begin
        selReg <= selReg - 1'b1;
        drive  <= drive >> 1;
      end
      if (strobes.resultCapture) begin
        pixDiv    <= divClamp;
        frqWord   <= frqHold;
        ctrlWord  <= baseReg | (W'(selReg) << SEL_POS);
        scaleWord <= (divWide << SCALE_SHIFT) + divWide * pixReg;
      end
    end
  end

  // R2
  drive_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ratioInit |-> ((drive >= LO_W && drive <= HI_W) || drive == '0));

  // R4
  sel_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.searchStep |=> (selReg != SEL_START));

  // R5
  clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.resultCapture |=> (pixDiv != '0 && 32'(pixDiv) <= 32'(DIV_MAX)));

endmodule

// File: rtl/pll_calc.sv
module pll_calc
  import pll_calc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] reqFreq,
  input  logic [W-1:0] sysFreq,
  input  logic [W-1:0] pixels,
  input  logic [W-1:0] ctrlBase,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] frqWord,
  output logic [W-1:0] ctrlWord,
  output logic [W-1:0] scaleWord
);

  calcStrobes_t strobes;
  calcStatus_t  status;

  pll_calc_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobes(strobes),
    .busy   (busy),
    .done   (done)
  );

  pll_calc_dp #(.W(W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqFreq  (reqFreq),
    .sysFreq  (sysFreq),
    .pixels   (pixels),
    .ctrlBase (ctrlBase),
    .status   (status),
    .frqWord  (frqWord),
    .ctrlWord (ctrlWord),
    .scaleWord(scaleWord)
  );

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!done && $past(!done)) |-> ($stable(frqWord) && $stable(ctrlWord) && $stable(scaleWord)));

endmodule

// File: tb/pll_calc_bench.sv
`timescale 1ns/1ps
module pll_calc_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] reqFreq = '0, sysFreq = '0, pixels = '0, ctrlBase = '0;
  logic busy, done;
  logic [31:0] frqWord, ctrlWord, scaleWord;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pll_calc u_pll_calc (
    .clk(clk), .rstN(rstN), .start(start),
    .reqFreq(reqFreq), .sysFreq(sysFreq), .pixels(pixels), .ctrlBase(ctrlBase),
    .busy(busy), .done(done),
    .frqWord(frqWord), .ctrlWord(ctrlWord), .scaleWord(scaleWord)
  );

  localparam int NV = 8;
  localparam logic [127:0] VEC [NV] = '{
    {32'd25_175_000,  32'd80_000_000,  32'd640,  32'h0000_0000},
    {32'd8_000_000,   32'd80_000_000,  32'd16,   32'h1000_0000},
    {32'd4_000_000,   32'd100_000_000, 32'd1,    32'h0380_0000},
    {32'd2_001,       32'd80_000_000,  32'd10,   32'h0000_0000},
    {32'd200_000_000, 32'd96_000_000,  32'd3,    32'h0000_00FF},
    {32'd13_500_000,  32'd64_000_000,  32'd720,  32'h0400_0000},
    {32'd65_000_000,  32'd80_000_000,  32'd1024, 32'h0000_0000},
    {32'd4_000_001,   32'd12_000_000,  32'd7,    32'h8000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] f, input logic [31:0] s, input logic [31:0] p,
                       input logic [31:0] b, output logic [31:0] eF, output logic [31:0] eC,
                       output logic [31:0] eS, output int lat);
    longint unsigned d = f;
    longint unsigned dv;
    int h = 0;
    int sc = 0;
    int sel = 7;
    while (d > 8_000_000) begin d = d >> 1; h++; end
    while (d < 4_000_000) begin d = d << 1; h++; end
    eF = 32'((d << 32) / s);
    d = d * 16;
    while (sel != 0 && d > (longint'(f) + longint'(f / 2))) begin
      sel--; d = d / 2; sc++;
    end
    dv = ((d + f / 2) & 64'hFFFF_FFFF) / f;
    if (dv < 1) dv = 1;
    if (dv > 255) dv = 255;
    eC = b | (32'(sel) << 23);
    eS = 32'((dv << 12) + dv * p);
    lat = 67 + h + sc;
  endtask

  task automatic runJob(input logic [127:0] v, input bit busyStart,
                        input logic [127:0] v2, output int lat);
    @(negedge clk);
    {reqFreq, sysFreq, pixels, ctrlBase} = v;
    start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 busy after start", {31'b0, busy}, 32'd1);
    if (busyStart) begin
      repeat (5) begin @(posedge clk); lat++; @(negedge clk); end
      {reqFreq, sysFreq, pixels, ctrlBase} = v2;
      start = 1'b1;
      @(posedge clk); lat++; @(negedge clk);
      start = 1'b0;
    end
    while (!done && lat < 400) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] eF, eC, eS;
    logic [31:0] hF, hC, hS;
    int eLat, lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 frqWord", frqWord, 32'd0);
    chk("R1 ctrlWord", ctrlWord, 32'd0);
    chk("R1 scaleWord", scaleWord, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      model(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0], eF, eC, eS, eLat);
      runJob(VEC[i], 1'b0, '0, lat);
      chk("R8 latency", 32'(lat), 32'(eLat));
      chk("R2 R3 frqWord", frqWord, eF);
      chk("R4 ctrlWord", ctrlWord, eC);
      chk("R5 scaleWord", scaleWord, eS);
      chk("R6 busy with done", {31'b0, busy}, 32'd1);
      hF = frqWord; hC = ctrlWord; hS = scaleWord;
      @(negedge clk);
      chk("R6 done one cycle", {31'b0, done}, 32'd0);
      repeat (20) @(negedge clk);
      chk("R9 frqWord hold", frqWord, hF);
      chk("R9 ctrlWord hold", ctrlWord, hC);
      chk("R9 scaleWord hold", scaleWord, hS);
      chk("R6 idle busy", {31'b0, busy}, 32'd0);
    end

    // R7: start while busy with other operands is ignored
    model(VEC[0][127:96], VEC[0][95:64], VEC[0][63:32], VEC[0][31:0], eF, eC, eS, eLat);
    runJob(VEC[0], 1'b1, VEC[4], lat);
    chk("R7 latency", 32'(lat), 32'(eLat));
    chk("R7 frqWord", frqWord, eF);
    chk("R7 ctrlWord", ctrlWord, eC);
    chk("R7 scaleWord", scaleWord, eS);
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R7 no second job", {31'b0, busy}, 32'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule